// File: doc/BRIEF.md
# Serial Status Flag Acknowledge Logic

This block keeps the status flags of an asynchronous serial port. The transmit and receive engines raise one-cycle set pulses. The host clears a flag with a two-step acknowledge. First it reads the status word while the flag is set. Then it touches the data register: a read for receive-side flags, or a write for the two transmit-side flags. Each status read captures which flags were set at that moment. Only those captured flags can be cleared by the following data access. A flag that comes up after the status read therefore survives until a fresh status read has seen it.

The block drives the 16-bit status word that the host reads. It also drives one interrupt request, formed from four flags that each have their own enable. The receiver-busy indication passes straight through to the status word and takes no part in the acknowledge.

Top module: `serial_status_ack`

## Requirements
- R1: After reset the status word reads 16'h0180, with only the transmit-empty and transmit-done flags set, and the interrupt request is low.
- R2: `set_flags` uses this bit order: bit 7 transmit-empty, bit 6 transmit-done, bit 5 receive-full, bit 4 idle, bit 3 overrun, bit 2 noise, bit 1 framing, bit 0 parity. In `stat_q` the same flags sit at bits 8, 7, 6, 4, 3, 2, 1 and 0, the receiver-busy input sits at bit 5, and bits 15 to 9 read as zero. A set pulse shows in `stat_q` from the cycle after the clock edge at which it was sampled.
- R3: A data read clears every receive-side flag (bits 6, 4, 3, 2, 1, 0) that was set at the most recent status read, provided no other data access came between them.
- R4: A data write clears the transmit-empty and transmit-done flags if they were set at the most recent status read, provided no other data access came between them.
- R5: A data read leaves the transmit-side flags unchanged, and a data write leaves the receive-side flags unchanged.
- R6: A data access with no status read since the previous data access clears nothing.
- R7: A flag that sets after the status read but before the data access stays set. It clears only after a later status read and data access.
- R8: If a set pulse and a clear hit the same flag in the same cycle, the flag stays set.
- R9: A combined long read (`long_rd`) clears the receive-side flags that are set at that moment and leaves the transmit-side flags set. A data write straight after it clears nothing.
- R10: A read of either byte of the status word captures all of its flags for the acknowledge.
- R11: `irq` is high exactly when at least one of these pairs has both members high: transmit-empty with `en_tx_irq`, transmit-done with `en_txdone_irq`, receive-full with `en_rx_irq`, or idle with `en_idle_irq`. The overrun, noise, framing and parity flags never raise it.
- R12: Status bit 5 follows `rx_active` in the same cycle, and the acknowledge sequence has no effect on it.
- R13: A data access uses up the captured set. A second data access before the next status read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_flags | input | 8 | One-cycle set pulses from the serial engines (order in R2) |
| rx_active | input | 1 | Live receiver-busy indication |
| stat_rd_hi | input | 1 | Host reads the upper byte of the status word |
| stat_rd_lo | input | 1 | Host reads the lower byte of the status word |
| long_rd | input | 1 | Host reads the status word and then the data register in one access |
| data_rd | input | 1 | Host reads the data register |
| data_wr | input | 1 | Host writes the data register |
| en_tx_irq | input | 1 | Interrupt enable for transmit-empty |
| en_txdone_irq | input | 1 | Interrupt enable for transmit-done |
| en_rx_irq | input | 1 | Interrupt enable for receive-full |
| en_idle_irq | input | 1 | Interrupt enable for idle |
| stat_q | output | 16 | Status word as read by the host |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench sets a framing flag between the status read and the data read. A design that clears every set flag, rather than only the captured ones, would lose it. It also pulses a set in the same cycle as an armed clear, which catches a design where the clear wins. It follows a long read with a data write and repeats data accesses without a fresh status read. A design that does not drop the captured set after use would clear transmit flags, or overrun, that no status read had seen. Finally, it reads only the upper status byte before clearing a lower-byte flag, and it sets overrun and the error flags with every enable high. This exposes per-byte arming and interrupt gating that leaks from the error flags.

// File: rtl/serial_status_ack.sv
module serial_status_ack #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        set_flags,
  input  logic              rx_active,
  input  logic              stat_rd_hi,
  input  logic              stat_rd_lo,
  input  logic              long_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              en_tx_irq,
  input  logic              en_txdone_irq,
  input  logic              en_rx_irq,
  input  logic              en_idle_irq,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  localparam logic [7:0] RX_GRP = 8'h3F;
  localparam logic [7:0] TX_GRP = 8'hC0;
  localparam logic [7:0] RST_V  = 8'hC0;
  localparam int         PAD_W  = STAT_W - 9;

  logic [7:0] flg, arm;

  wire       any_stat = stat_rd_hi | stat_rd_lo;
  wire [7:0] rx_src   = long_rd ? flg : arm;
  wire [7:0] clr_rx   = (data_rd | long_rd) ? (rx_src & RX_GRP) : 8'h00;
  wire [7:0] clr_tx   = data_wr ? (arm & TX_GRP) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg <= RST_V;
      arm <= 8'h00;
    end else begin
      flg <= (flg & ~(clr_rx | clr_tx)) | set_flags;
      if (long_rd)
        arm <= 8'h00;
      else if (any_stat)
        arm <= flg;
      else if (data_rd | data_wr)
        arm <= 8'h00;
    end
  end

  assign stat_q = {{PAD_W{1'b0}}, flg[7:5], rx_active, flg[4:0]};

  assign irq = (flg[7] & en_tx_irq) | (flg[6] & en_txdone_irq) |
               (flg[5] & en_rx_irq) | (flg[4] & en_idle_irq);
endmodule

// File: rtl/serial_status_ack_chk.sv
module serial_status_ack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  set_flags,
  input logic        rx_active,
  input logic        stat_rd_hi,
  input logic        stat_rd_lo,
  input logic        long_rd,
  input logic        data_rd,
  input logic        data_wr,
  input logic        en_tx_irq,
  input logic        en_txdone_irq,
  input logic        en_rx_irq,
  input logic        en_idle_irq,
  input logic [15:0] stat_q,
  input logic        irq
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[15:9] == 7'd0);

  // R8
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags[5] |=> stat_q[6]);

  // R8
  tx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags[7] |=> stat_q[8]);

  // R5
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[6] && !data_rd && !long_rd) |=> stat_q[6]);

  // R4
  tx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[8]) |-> $past(data_wr));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_tx_irq || en_txdone_irq || en_rx_irq || en_idle_irq) |-> !irq);
endmodule

bind serial_status_ack serial_status_ack_chk u_chk (.*);

// File: tb/serial_status_ack_bench.sv
module serial_status_ack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  set_flags = 8'h00;
  logic        rx_active = 1'b0;
  logic        stat_rd_hi = 1'b0, stat_rd_lo = 1'b0, long_rd = 1'b0;
  logic        data_rd = 1'b0, data_wr = 1'b0;
  logic        en_tx_irq = 1'b0, en_txdone_irq = 1'b0, en_rx_irq = 1'b0, en_idle_irq = 1'b0;
  logic [15:0] stat_q;
  logic        irq;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  serial_status_ack u_serial_status_ack (.*);

  task automatic step(input logic [7:0] s, input logic rh, input logic rl,
                      input logic lr, input logic dr, input logic dw);
    set_flags = s; stat_rd_hi = rh; stat_rd_lo = rl; long_rd = lr;
    data_rd = dr; data_wr = dw;
    @(posedge clk); #1;
    set_flags = 8'h00; stat_rd_hi = 0; stat_rd_lo = 0; long_rd = 0;
    data_rd = 0; data_wr = 0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clean();
    step(8'h00, 0, 1, 0, 0, 0); step(8'h00, 0, 0, 0, 1, 0);
    step(8'h00, 0, 1, 0, 0, 0); step(8'h00, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 stat", stat_q, 16'h0180);
    chk("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_set_rx_clear();
    step(8'h24, 0, 0, 0, 0, 0);
    chk("R2 layout", stat_q, 16'h01C4);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h00, 0, 0, 0, 1, 0);
    chk("R3/R5 rx clear keeps tx", stat_q, 16'h0180);
  endtask

  task automatic t_tx_clear();
    step(8'h20, 0, 0, 0, 0, 0);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0, 1);
    chk("R4/R5 write clears tx keeps rx", stat_q, 16'h0040);
  endtask

  task automatic t_no_arm();
    step(8'h00, 0, 0, 0, 1, 0);
    chk("R6 read without arm", stat_q, 16'h0040);
    step(8'h80, 0, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0, 1);
    chk("R6 write without arm", stat_q, 16'h0140);
    clean();
    chk("R6 cleanup", stat_q, 16'h0000);
  endtask

  task automatic t_late_set();
    step(8'h20, 0, 0, 0, 0, 0);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h02, 0, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 1, 0);
    chk("R7 late flag survives", stat_q, 16'h0002);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h00, 0, 0, 0, 1, 0);
    chk("R7 late flag clears later", stat_q, 16'h0000);
  endtask

  task automatic t_set_wins();
    step(8'h20, 0, 0, 0, 0, 0);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h20, 0, 0, 0, 1, 0);
    chk("R8 set beats clear", stat_q, 16'h0040);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h00, 0, 0, 0, 1, 0);
  endtask

  task automatic t_long();
    step(8'hA0, 0, 0, 0, 0, 0);
    step(8'h00, 0, 0, 1, 0, 0);
    chk("R9 long read", stat_q, 16'h0100);
    step(8'h00, 0, 0, 0, 0, 1);
    chk("R9 write after long read", stat_q, 16'h0100);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0, 1);
  endtask

  task automatic t_hi_byte();
    step(8'h08, 0, 0, 0, 0, 0);
    step(8'h00, 1, 0, 0, 0, 0);
    step(8'h00, 0, 0, 0, 1, 0);
    chk("R10 upper byte arms low flag", stat_q, 16'h0000);
  endtask

  task automatic t_irq();
    step(8'h80, 0, 0, 0, 0, 0);
    chk("R11 tx masked", {15'd0, irq}, 16'd0);
    en_tx_irq = 1; #1;
    chk("R11 tx enabled", {15'd0, irq}, 16'd1);
    en_tx_irq = 0; clean();
    step(8'h40, 0, 0, 0, 0, 0); en_txdone_irq = 1; #1;
    chk("R11 txdone", {15'd0, irq}, 16'd1);
    en_txdone_irq = 0; clean();
    step(8'h20, 0, 0, 0, 0, 0); en_rx_irq = 1; #1;
    chk("R11 rx", {15'd0, irq}, 16'd1);
    en_rx_irq = 0; clean();
    step(8'h10, 0, 0, 0, 0, 0); en_idle_irq = 1; #1;
    chk("R11 idle", {15'd0, irq}, 16'd1);
    clean();
    step(8'h0F, 0, 0, 0, 0, 0);
    en_tx_irq = 1; en_txdone_irq = 1; en_rx_irq = 1; #1;
    chk("R11 error flags silent", {15'd0, irq}, 16'd0);
    en_tx_irq = 0; en_txdone_irq = 0; en_rx_irq = 0; en_idle_irq = 0;
    clean();
  endtask

  task automatic t_busy();
    rx_active = 1; #1;
    chk("R12 busy shown", stat_q, 16'h0020);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h00, 0, 0, 0, 1, 0);
    chk("R12 busy untouched", stat_q, 16'h0020);
    rx_active = 0; #1;
    chk("R12 busy drops", stat_q, 16'h0000);
  endtask

  task automatic t_consume();
    step(8'h08, 0, 0, 0, 0, 0);
    step(8'h00, 0, 1, 0, 0, 0);
    step(8'h00, 0, 0, 0, 0, 1);
    chk("R13 write keeps overrun", stat_q, 16'h0008);
    step(8'h00, 0, 0, 0, 1, 0);
    chk("R13 second access clears nothing", stat_q, 16'h0008);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_set_rx_clear();
    t_tx_clear();
    t_no_arm();
    t_late_set();
    t_set_wins();
    t_long();
    t_hi_byte();
    t_irq();
    t_busy();
    t_consume();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule